// File: doc/BRIEF.md
# Headset Button Level Detector

This block watches the microphone line of a headset jack through an 8-bit SAR ADC and decides which of up to eight buttons is held. Each new ADC code, marked by a valid strobe, is compared against a programmable threshold per key level. Each comparator has a hysteresis band set by one shared coefficient. Level 0 is the lowest line voltage. The lowest comparator that reports "below" names the candidate key. The candidate must repeat for a programmable number of samples before the reported key level changes.

Each change of the reported key raises a press event for the new key and a release event for the old one. Two jack-detect pins are synchronised, combined by OR or AND, and given a selectable polarity. The combined signal is then filtered over a selectable window before insertion or ejection is declared. All events land in a status register that software clears by writing ones. Each status bit can be masked from the single interrupt line.

Top module: `hsbtn_detect`

## Requirements
- R1: Comparator k turns on when code + hyst < thr[k] and turns off when code > thr[k] + hyst, both evaluated in 9-bit arithmetic. Otherwise it keeps its state. It changes only on cycles with `smp_valid` high.
- R2: The candidate key is the lowest index whose comparator is on. `key_level` is one-hot with bit k meaning key k, and all zeros means no key is held.
- R3: `key_level` takes the candidate at the clock edge of the N-th consecutive valid sample with the same candidate, where N = `cfg_key_db` and 0 acts as 1. Cycles without `smp_valid` leave it unchanged.
- R4: When `key_level` changes, status bit 2+k is set for a new key k. Status bit 2+NLVL+j is set for a previous key j. Both bits are set in the same edge that changes `key_level`.
- R5: The detect signal is `jack_a | jack_b`, or `jack_a & jack_b` when `cfg_jack_and` is 1. It means "present" when high if `cfg_jack_rise` is 1, and when low otherwise. Each pin passes a two-flop synchroniser.
- R6: `jack_in` flips after the synchronised present value has differed from it for JACK_BASE << `cfg_jack_sel` consecutive cycles. Insertion sets status bit 0 and ejection sets status bit 1.
- R7: A cycle with `clr_we` high clears status bits selected by `clr_data`. Clear bit 0 or 1 clears status bit 0. Clear bit 2 or 3 clears status bit 1. Clear bit 4+i clears status bit 2+i.
- R8: A status bit that is set and cleared in the same cycle ends up set.
- R9: `irq` is high exactly when some status bit is 1 and its `irq_mask` bit is 0. The mask never changes the status.
- R10: After reset `key_level`, `jack_in`, `irq_status` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | New ADC code present this cycle |
| smp_code | input | CODE_W | ADC code of the microphone line |
| cfg_thr | input | NLVL*CODE_W | Threshold of level k in bits [k*CODE_W +: CODE_W], ascending |
| cfg_hyst | input | HYST_W | Shared hysteresis coefficient |
| cfg_key_db | input | KDB_W | Required consecutive samples (0 acts as 1) |
| jack_a | input | 1 | First jack-detect pin |
| jack_b | input | 1 | Second jack-detect pin |
| cfg_jack_rise | input | 1 | 1: present when combined signal high |
| cfg_jack_and | input | 1 | 1: AND the pins, 0: OR them |
| cfg_jack_sel | input | JSEL_W | Jack filter window selector |
| clr_we | input | 1 | Clear strobe |
| clr_data | input | CLR_W | Write-one-to-clear pattern |
| irq_mask | input | ST_W | 1 masks the matching status bit from irq |
| key_level | output | NLVL | One-hot detected key, zero when released |
| jack_in | output | 1 | Filtered jack present state |
| irq_status | output | ST_W | Sticky event bits |
| irq | output | 1 | Interrupt line |

## Verification
The key filter and the clear path can act on the same status bit in one edge. The bench commits a key release exactly in the cycle that writes a clear for that release bit. In the same write it also clears the matching press bit, which is set already. The release bit must survive and the press bit must drop.

A jack flip and a clear of its status bit can also meet in one edge, and a bound property covers this case. After any clear of the insertion bit, the bit must read zero on the next cycle unless `jack_in` rose in that same edge.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
  // status layout: [0] insert, [1] eject, [2 +: n] press, [2+n +: n] release
  function automatic int st_width(input int n);
    return 2 + 2 * n;
  endfunction
  // clear layout: [1:0] insert, [3:2] eject, [4 +: 2n] key events
  function automatic int clr_width(input int n);
    return 4 + 2 * n;
  endfunction
endpackage

// File: rtl/hsb_level_cmp.sv
module hsb_level_cmp #(
  parameter int NLVL   = 8,
  parameter int CODE_W = 8,
  parameter int HYST_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic [CODE_W-1:0]        smp_code,
  input  logic [NLVL*CODE_W-1:0]   cfg_thr,
  input  logic [HYST_W-1:0]        cfg_hyst,
  output logic [NLVL-1:0]          below_nxt
);
  localparam int ZW = CODE_W + 1;

  logic [NLVL-1:0] below_q;
  logic [ZW-1:0]   code_x;
  logic [ZW-1:0]   lo_sum;

  assign code_x = {1'b0, smp_code};
  assign lo_sum = code_x + ZW'(cfg_hyst);

  for (genvar k = 0; k < NLVL; k++) begin : g_cmp
    logic [ZW-1:0] thr_x;
    logic [ZW-1:0] hi_sum;
    assign thr_x  = {1'b0, cfg_thr[k*CODE_W +: CODE_W]};
    assign hi_sum = thr_x + ZW'(cfg_hyst);

    always_comb begin
      below_nxt[k] = below_q[k];
      if (smp_valid) begin
        if (lo_sum < thr_x)        below_nxt[k] = 1'b1;
        else if (code_x > hi_sum)  below_nxt[k] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         below_q <= '0;
    else if (smp_valid) below_q <= below_nxt;
  end
endmodule

// File: rtl/hsb_key_debounce.sv
module hsb_key_debounce #(
  parameter int NLVL  = 8,
  parameter int KDB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [NLVL-1:0]  cand,
  input  logic [KDB_W-1:0] cfg_db,
  output logic [NLVL-1:0]  level_q,
  output logic [NLVL-1:0]  press_ev,
  output logic [NLVL-1:0]  release_ev
);
  logic [NLVL-1:0]  prev_q, prev_nxt;
  logic [KDB_W-1:0] run_q, run_nxt, need;
  logic [NLVL-1:0]  level_nxt;
  logic             commit;

  assign need = (cfg_db == '0) ? KDB_W'(1) : cfg_db;

  always_comb begin
    prev_nxt = prev_q;
    run_nxt  = run_q;
    if (smp_valid) begin
      prev_nxt = cand;
      if (cand != prev_q)       run_nxt = KDB_W'(1);
      else if (run_q != '1)     run_nxt = run_q + KDB_W'(1);
    end
    commit     = smp_valid && (run_nxt >= need) && (cand != level_q);
    level_nxt  = commit ? cand : level_q;
    press_ev   = commit ? cand : '0;
    release_ev = commit ? level_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      run_q   <= '0;
      level_q <= '0;
    end else if (smp_valid) begin
      prev_q  <= prev_nxt;
      run_q   <= run_nxt;
      level_q <= level_nxt;
    end
  end
endmodule

// File: rtl/hsb_jack_filter.sv
module hsb_jack_filter #(
  parameter int JACK_BASE = 16,
  parameter int JSEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              cfg_rise,
  input  logic              cfg_and,
  input  logic [JSEL_W-1:0] cfg_sel,
  output logic              jack_q,
  output logic              ins_ev,
  output logic              ej_ev
);
  localparam int MAXLEN = JACK_BASE << ((1 << JSEL_W) - 1);
  localparam int CW     = $clog2(MAXLEN + 1);

  logic [1:0]    sa_q, sb_q;
  logic          comb_sig, present;
  logic [CW-1:0] len, cnt_q, cnt_nxt;
  logic          jack_nxt;

  assign comb_sig = cfg_and ? (sa_q[1] & sb_q[1]) : (sa_q[1] | sb_q[1]);
  assign present  = cfg_rise ? comb_sig : ~comb_sig;
  assign len      = CW'(JACK_BASE) << cfg_sel;

  always_comb begin
    cnt_nxt  = '0;
    jack_nxt = jack_q;
    if (present != jack_q) begin
      if (cnt_q >= len - CW'(1)) jack_nxt = present;
      else                       cnt_nxt  = cnt_q + CW'(1);
    end
    ins_ev = jack_nxt & ~jack_q;
    ej_ev  = ~jack_nxt & jack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q   <= '0;
      sb_q   <= '0;
      cnt_q  <= '0;
      jack_q <= 1'b0;
    end else begin
      sa_q   <= {sa_q[0], pin_a};
      sb_q   <= {sb_q[0], pin_b};
      cnt_q  <= cnt_nxt;
      jack_q <= jack_nxt;
    end
  end
endmodule

// File: rtl/hsb_irq_reg.sv
module hsb_irq_reg #(
  parameter int NLVL = 8,
  localparam int ST_W  = hsb_pkg::st_width(NLVL),
  localparam int CLR_W = hsb_pkg::clr_width(NLVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ST_W-1:0]  set_ev,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_data,
  input  logic [ST_W-1:0]  mask,
  output logic [ST_W-1:0]  status_q,
  output logic             irq
);
  logic [ST_W-1:0] clr_eff, status_nxt;

  always_comb begin
    clr_eff = '0;
    if (clr_we) begin
      clr_eff[0]             = clr_data[0] | clr_data[1];
      clr_eff[1]             = clr_data[2] | clr_data[3];
      clr_eff[ST_W-1:2]      = clr_data[CLR_W-1:4];
    end
    status_nxt = (status_q & ~clr_eff) | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_nxt;
  end

  assign irq = |(status_q & ~mask);
endmodule

// File: rtl/hsbtn_detect.sv
module hsbtn_detect #(
  parameter int NLVL      = 8,
  parameter int CODE_W    = 8,
  parameter int HYST_W    = 4,
  parameter int KDB_W     = 4,
  parameter int JACK_BASE = 16,
  parameter int JSEL_W    = 2,
  localparam int ST_W  = hsb_pkg::st_width(NLVL),
  localparam int CLR_W = hsb_pkg::clr_width(NLVL)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_valid,
  input  logic [CODE_W-1:0]      smp_code,
  input  logic [NLVL*CODE_W-1:0] cfg_thr,
  input  logic [HYST_W-1:0]      cfg_hyst,
  input  logic [KDB_W-1:0]       cfg_key_db,
  input  logic                   jack_a,
  input  logic                   jack_b,
  input  logic                   cfg_jack_rise,
  input  logic                   cfg_jack_and,
  input  logic [JSEL_W-1:0]      cfg_jack_sel,
  input  logic                   clr_we,
  input  logic [CLR_W-1:0]       clr_data,
  input  logic [ST_W-1:0]        irq_mask,
  output logic [NLVL-1:0]        key_level,
  output logic                   jack_in,
  output logic [ST_W-1:0]        irq_status,
  output logic                   irq
);
  logic [NLVL-1:0] below_nxt, cand, press_ev, release_ev;
  logic            ins_ev, ej_ev;
  logic [ST_W-1:0] set_ev;

  hsb_level_cmp #(.NLVL(NLVL), .CODE_W(CODE_W), .HYST_W(HYST_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .cfg_thr(cfg_thr), .cfg_hyst(cfg_hyst), .below_nxt(below_nxt)
  );

  // lowest active comparator wins
  assign cand = below_nxt & (~below_nxt + NLVL'(1));

  hsb_key_debounce #(.NLVL(NLVL), .KDB_W(KDB_W)) u_kdb (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cand(cand),
    .cfg_db(cfg_key_db), .level_q(key_level), .press_ev(press_ev),
    .release_ev(release_ev)
  );

  hsb_jack_filter #(.JACK_BASE(JACK_BASE), .JSEL_W(JSEL_W)) u_jack (
    .clk(clk), .rst_n(rst_n), .pin_a(jack_a), .pin_b(jack_b),
    .cfg_rise(cfg_jack_rise), .cfg_and(cfg_jack_and), .cfg_sel(cfg_jack_sel),
    .jack_q(jack_in), .ins_ev(ins_ev), .ej_ev(ej_ev)
  );

  assign set_ev = {release_ev, press_ev, ej_ev, ins_ev};

  hsb_irq_reg #(.NLVL(NLVL)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_we(clr_we),
    .clr_data(clr_data), .mask(irq_mask), .status_q(irq_status), .irq(irq)
  );
endmodule

// File: rtl/hsb_checker.sv
module hsb_checker #(
  parameter int NLVL  = 8,
  parameter int ST_W  = 18,
  parameter int CLR_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic [NLVL-1:0]  key_level,
  input logic             jack_in,
  input logic [ST_W-1:0]  irq_status,
  input logic             clr_we,
  input logic [CLR_W-1:0] clr_data
);
  assert_level_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(key_level));

  assert_hold_without_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(key_level));

  assert_press_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((key_level != $past(key_level)) && (key_level != '0))
      |-> ((irq_status[2 +: NLVL] & key_level) != '0));

  assert_release_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((key_level != $past(key_level)) && ($past(key_level) != '0))
      |-> ((irq_status[2+NLVL +: NLVL] & $past(key_level)) != '0));

  assert_insert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jack_in) |-> irq_status[0]);

  assert_insert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (clr_data[0] || clr_data[1])) |=> (!irq_status[0] || $rose(jack_in)));
endmodule

bind hsbtn_detect hsb_checker #(.NLVL(NLVL), .ST_W(ST_W), .CLR_W(CLR_W)) u_hsb_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .key_level(key_level),
  .jack_in(jack_in), .irq_status(irq_status), .clr_we(clr_we), .clr_data(clr_data)
);

// File: tb/test_hsbtn_detect.sv
module test_hsbtn_detect;
  localparam int NLVL = 8, CODE_W = 8, ST_W = 18, CLR_W = 20, JB = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic smp_valid;
  logic [CODE_W-1:0] smp_code;
  logic [NLVL*CODE_W-1:0] cfg_thr;
  logic [3:0] cfg_hyst, cfg_key_db;
  logic jack_a, jack_b, cfg_jack_rise, cfg_jack_and;
  logic [1:0] cfg_jack_sel;
  logic clr_we;
  logic [CLR_W-1:0] clr_data;
  logic [ST_W-1:0] irq_mask;
  logic [NLVL-1:0] key_level;
  logic jack_in, irq;
  logic [ST_W-1:0] irq_status;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hsbtn_detect i_hsbtn_detect (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .cfg_thr(cfg_thr), .cfg_hyst(cfg_hyst), .cfg_key_db(cfg_key_db),
    .jack_a(jack_a), .jack_b(jack_b), .cfg_jack_rise(cfg_jack_rise),
    .cfg_jack_and(cfg_jack_and), .cfg_jack_sel(cfg_jack_sel),
    .clr_we(clr_we), .clr_data(clr_data), .irq_mask(irq_mask),
    .key_level(key_level), .jack_in(jack_in), .irq_status(irq_status), .irq(irq)
  );

  // {code, expected key_level after the sample}; thresholds 30+28k, hyst 4, N=2
  localparam logic [15:0] VEC [10] = '{
    {8'd250, 8'h00},  // R2 above all thresholds: released
    {8'd100, 8'h00},  // R3 first sample of key 3
    {8'd100, 8'h08},  // R3 second sample commits key 3
    {8'd112, 8'h08},  // R1 inside band of level 3
    {8'd116, 8'h08},  // R1 still inside band (off needs >118)
    {8'd119, 8'h08},  // R1 level 3 off -> candidate key 4
    {8'd119, 8'h10},  // R3 commit key 4
    {8'd20,  8'h10},  // R2 candidate key 0, one sample only
    {8'd250, 8'h10},  // R3 glitch rejected
    {8'd250, 8'h00}   // R3 release committed
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sample(input logic [7:0] code);
    smp_code  = code;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear(input logic [CLR_W-1:0] pat);
    clr_we   = 1'b1;
    clr_data = pat;
    @(negedge clk);
    clr_we   = 1'b0;
    clr_data = '0;
  endtask

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_code = '0;
    for (int k = 0; k < NLVL; k++) cfg_thr[k*CODE_W +: CODE_W] = 8'(30 + 28 * k);
    cfg_hyst = 4'd4; cfg_key_db = 4'd2;
    jack_a = 1'b1; jack_b = 1'b1; cfg_jack_rise = 1'b0; cfg_jack_and = 1'b0;
    cfg_jack_sel = 2'd0; clr_we = 1'b0; clr_data = '0; irq_mask = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R10 key_level", 32'(key_level), 32'h0);
    check("R10 jack_in", 32'(jack_in), 32'h0);
    check("R10 irq_status", 32'(irq_status), 32'h0);
    check("R10 irq", 32'(irq), 32'h0);

    for (int i = 0; i < 10; i++) begin
      sample(VEC[i][15:8]);
      check($sformatf("R1 R2 R3 vector %0d", i), 32'(key_level), 32'(VEC[i][7:0]));
    end
    // press 3,4 at bits 5,6; release 3,4 at bits 13,14
    check("R4 status after table", 32'(irq_status), 32'h6060);
    check("R9 irq with no mask", 32'(irq), 32'h1);
    clear('1);
    check("R7 clear all", 32'(irq_status), 32'h0);

    // jack: OR with low-active polarity; one pin low is not present
    jack_a = 1'b0;
    idle(40);
    check("R5 OR keeps absent", 32'(jack_in), 32'h0);
    jack_b = 1'b0;
    idle(JB + 1);
    check("R6 insert not yet", 32'(jack_in), 32'h0);
    idle(1);
    check("R6 insert", 32'(jack_in), 32'h1);
    check("R6 insert flag", 32'(irq_status), 32'h1);
    clear(20'h2);
    check("R7 clear bit1 clears insert", 32'(irq_status), 32'h0);

    // AND with high-active polarity: pins low -> absent, window doubled
    cfg_jack_and = 1'b1; cfg_jack_rise = 1'b1; cfg_jack_sel = 2'd1;
    idle(2 * JB - 1);
    check("R6 eject not yet", 32'(jack_in), 32'h1);
    idle(1);
    check("R5 R6 eject", 32'(jack_in), 32'h0);
    check("R6 eject flag", 32'(irq_status), 32'h2);
    clear(20'h8);
    check("R7 clear bit3 clears eject", 32'(irq_status), 32'h0);

    // R3: codes without valid are ignored
    smp_code = 8'd20;
    idle(5);
    check("R3 no valid no change", 32'(key_level), 32'h0);
    // R3: N=0 acts as 1
    cfg_key_db = 4'd0;
    sample(8'd20);
    check("R3 N=0 immediate", 32'(key_level), 32'h01);
    check("R4 press key0", 32'(irq_status), 32'h4);

    // R8: release of key0 (bit10) with same-cycle clear of bits 10 and 2
    smp_code = 8'd250; smp_valid = 1'b1;
    clr_we = 1'b1; clr_data = 20'h1010;
    @(negedge clk);
    smp_valid = 1'b0; clr_we = 1'b0; clr_data = '0;
    check("R8 set wins over clear", 32'(irq_status), 32'h400);
    check("R2 released", 32'(key_level), 32'h0);

    irq_mask = ~18'h400;
    idle(1);
    check("R9 unmasked bit raises irq", 32'(irq), 32'h1);
    irq_mask = '1;
    idle(1);
    check("R9 all masked", 32'(irq), 32'h0);
    check("R9 mask leaves status", 32'(irq_status), 32'h400);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule